// File: doc/BRIEF.md
# Parity-Protected Direct-Mapped Cache Slice with Line Flush

This block is one slice of a read-only, direct-mapped cache. Each stored 32-bit word has four check bits beside it, and so does the tag word of each line. A tag word holds an 8-bit context stamp in bits [31:24] and the address tag in its low bits. A normal read that hits checks the parity of both the tag word and the addressed data word. If both are clean, the word is returned. If either is wrong, no data is returned. The block then drops the whole line, marks the response as "retry", and bumps a 2-bit saturating error counter for tags, for data, or for both. When the caller reissues the access, it misses, and the line is refetched from memory over a simple burst refill port.

A control register holds:
- a diagnostic-enable bit,
- the context value stamped into tags on refill,
- the two error counters.

While diagnostics are enabled, four address-space codes reach the raw stored state:

| Code | Access |
|------|--------|
| 0xC | tag parity bits |
| 0xD | context stamp |
| 0xE | data parity bits |
| 0xF | raw data word |

Diagnostic writes store exactly what is given, without recomputing any parity. This is how software, or a test, plants an error.

The controller is one state machine with five states:
- **IDLE**: waits for a request; taking one moves to LOOK.
- **LOOK**: serves the request. A diagnostic access or an ignored write goes to RESP. A clean hit goes to RESP. A hit with bad parity goes to FLUSH. A miss goes to FILL.
- **FILL**: takes one word per memory beat. On the last beat it writes the tag, sets the line valid and returns to LOOK.
- **FLUSH**: clears the line's valid bit, raises the retry response and counts the error, then goes to IDLE.
- **RESP**: presents the data for one cycle, then goes to IDLE.

Top module: `cpc_cache`

## Requirements
- R1: On refill, every stored word gets four even-parity bits. Bit i is the XOR of bits [8i+7:8i] of the word. The tag word {ctx[7:0], zeros, tag} gets its four bits the same way. Here tag is address bits [15:7] and index is address bits [6:4].
- R2: A normal read that misses raises mem_req with mem_addr set to the line-aligned address. It accepts WORDS beats, one word per mem_valid cycle, in ascending word order. It then responds with the memory word for the requested address.
- R3: A normal read that hits a valid line with clean parity responds with the stored word and does not raise mem_req.
- R4: A hit whose data word fails parity gives resp_valid with resp_retry=1 and resp_data=0. It raises no mem_req and increments the data error counter (control bits [5:4]).
- R5: A hit whose tag word fails parity gives the same retry response and increments the tag error counter (control bits [3:2]).
- R6: After a flush, the same access misses and refills the line, after which it returns correct data.
- R7: Each error counter stops at 3.
- R8: A control write whose counter field is zero clears that counter. A nonzero value in the field leaves the counter unchanged. Bit 0 is the diagnostic enable and bits [15:8] are the context, both written directly.
- R9: When bit 0 of the control register is 1, reads with asi 0xC, 0xD, 0xE and 0xF return the following: tag parity in [3:0], context in [7:0], parity of the addressed word in [3:0], and the raw addressed word, respectively.
- R10: Diagnostic writes replace the selected field (tag parity, context, data parity or data word) without recomputing parity, and respond with data 0.
- R11: A normal write is ignored. It responds with data 0, starts no refill and changes no stored word.
- R12: With bit 0 clear, asi codes 0xC–0xF act as normal reads.
- R13: After reset, req_ready=1, resp_valid=0, mem_req=0 and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_we | input | 1 | Request is a write |
| req_asi | input | 4 | Address-space code |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_retry | output | 1 | Access failed parity; reissue it |
| resp_data | output | 32 | Read data |
| mem_req | output | 1 | Refill in progress |
| mem_addr | output | AW | Line-aligned refill address |
| mem_valid | input | 1 | Refill beat present |
| mem_data | input | 32 | Refill beat data |
| ctl_we | input | 1 | Control register write |
| ctl_wdata | input | 32 | Control write value |
| ctl_rdata | output | 32 | Control register contents |

## Verification
The hardest states to reach from the ports are a valid line that holds a bad tag or data parity, and a counter already sitting at 3 when another error arrives. Refill always writes clean parity, so neither state occurs in normal operation. The bench therefore enables diagnostics and uses 0xC–0xF writes to replace a parity nibble, the context stamp or a raw word on a line that is already cached. It then issues a normal read to that line. This sequence is repeated until the data counter has taken more errors than it can hold.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL,
        ST_FLUSH,
        ST_RESP
    } cpc_state_e;

    localparam logic [1:0] DG_TPAR = 2'd0;
    localparam logic [1:0] DG_CTX  = 2'd1;
    localparam logic [1:0] DG_DPAR = 2'd2;
    localparam logic [1:0] DG_WORD = 2'd3;
endpackage

// File: rtl/cpc_parity.sv
module cpc_parity #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] word,
    output logic [BYTES-1:0]   par
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign par[b] = ^word[8*b +: 8];
    end
endmodule

// File: rtl/cpc_ctlreg.sv
module cpc_ctlreg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic        inc_tag,
    input  logic        inc_data,
    output logic        diag_en,
    output logic [7:0]  ctx,
    output logic [31:0] rdata
);
    logic       ps_q;
    logic [7:0] ctx_q;
    logic [1:0] tag_cnt_q, data_cnt_q;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata[31:16], wdata[7:6], wdata[1]};

    function automatic logic [1:0] sat_step(input logic [1:0] c, input logic inc);
        return (inc && c != 2'd3) ? c + 2'd1 : c;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q       <= 1'b0;
            ctx_q      <= '0;
            tag_cnt_q  <= '0;
            data_cnt_q <= '0;
        end else begin
            if (we) begin
                ps_q  <= wdata[0];
                ctx_q <= wdata[15:8];
            end
            if (we && wdata[3:2] == 2'd0) tag_cnt_q <= '0;
            else                          tag_cnt_q <= sat_step(tag_cnt_q, inc_tag);
            if (we && wdata[5:4] == 2'd0) data_cnt_q <= '0;
            else                          data_cnt_q <= sat_step(data_cnt_q, inc_data);
        end
    end

    assign diag_en = ps_q;
    assign ctx     = ctx_q;
    assign rdata   = {16'b0, ctx_q, 2'b0, data_cnt_q, tag_cnt_q, 1'b0, ps_q};

    a_r7_data_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (data_cnt_q == 2'd3 && !we) |=> data_cnt_q == 2'd3);
    a_r7_tag_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_cnt_q == 2'd3 && !we) |=> tag_cnt_q == 2'd3);
    a_r8_clear_data: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[5:4] == 2'd0) |=> data_cnt_q == 2'd0);
    a_r8_keep_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[3:2] != 2'd0 && !inc_tag) |=> $stable(tag_cnt_q));
endmodule

// File: rtl/cpc_store.sv
module cpc_store #(
    parameter int LINES = 8,
    parameter int WORDS = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [OFF_W-1:0] rd_off,
    output logic             rd_valid,
    output logic [31:0]      rd_tagw,
    output logic [3:0]       rd_tpar,
    output logic [31:0]      rd_data,
    output logic [3:0]       rd_dpar,
    input  logic             wd_en,
    input  logic [OFF_W-1:0] wd_off,
    input  logic [31:0]      wd_data,
    input  logic [3:0]       wd_par,
    input  logic             wt_en,
    input  logic [31:0]      wt_word,
    input  logic [3:0]       wt_par,
    input  logic             set_valid,
    input  logic             clr_valid
);
    logic [31:0]      data_q [LINES][WORDS];
    logic [3:0]       dpar_q [LINES][WORDS];
    logic [31:0]      tagw_q [LINES];
    logic [3:0]       tpar_q [LINES];
    logic [LINES-1:0] valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int l = 0; l < LINES; l++) begin
                tagw_q[l] <= '0;
                tpar_q[l] <= '0;
                for (int w = 0; w < WORDS; w++) begin
                    data_q[l][w] <= '0;
                    dpar_q[l][w] <= '0;
                end
            end
        end else begin
            if (wd_en) begin
                data_q[idx][wd_off] <= wd_data;
                dpar_q[idx][wd_off] <= wd_par;
            end
            if (wt_en) begin
                tagw_q[idx] <= wt_word;
                tpar_q[idx] <= wt_par;
            end
            if (set_valid)      valid_q[idx] <= 1'b1;
            else if (clr_valid) valid_q[idx] <= 1'b0;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_tagw  = tagw_q[idx];
    assign rd_tpar  = tpar_q[idx];
    assign rd_data  = data_q[idx][rd_off];
    assign rd_dpar  = dpar_q[idx][rd_off];

    a_r6_flush_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !set_valid) |=> !valid_q[$past(idx)]);
    a_r2_fill_sets_line: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> valid_q[$past(idx)]);
endmodule

// File: rtl/cpc_cache.sv
module cpc_cache
    import cpc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LINES = 8,
    parameter int WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [3:0]    req_asi,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          resp_valid,
    output logic          resp_retry,
    output logic [31:0]   resp_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [31:0]   mem_data,
    input  logic          ctl_we,
    input  logic [31:0]   ctl_wdata,
    output logic [31:0]   ctl_rdata
);
    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(WORDS);
    localparam int TAG_W = AW - 2 - OFF_W - IDX_W;
    localparam int PAD_W = 32 - 8 - TAG_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    cpc_state_e state_q, state_n;

    logic          lat_we;
    logic [3:0]    lat_asi;
    logic [AW-1:0] lat_addr;
    logic [31:0]   lat_wdata;
    logic [OFF_W-1:0] beat_q;
    logic [31:0]   rdata_q, rdata_n;
    logic          tag_err_q, data_err_q;

    logic [IDX_W-1:0] lat_idx;
    logic [OFF_W-1:0] lat_off;
    logic [TAG_W-1:0] lat_tag;
    logic             unused_lowbits;

    assign lat_idx = lat_addr[2+OFF_W +: IDX_W];
    assign lat_off = lat_addr[2 +: OFF_W];
    assign lat_tag = lat_addr[AW-1 -: TAG_W];
    assign unused_lowbits = ^lat_addr[1:0];

    logic        diag_en;
    logic [7:0]  ctx;
    logic        inc_tag, inc_data;

    cpc_ctlreg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl_we),
        .wdata   (ctl_wdata),
        .inc_tag (inc_tag),
        .inc_data(inc_data),
        .diag_en (diag_en),
        .ctx     (ctx),
        .rdata   (ctl_rdata)
    );

    logic        rd_valid;
    logic [31:0] rd_tagw, rd_data;
    logic [3:0]  rd_tpar, rd_dpar;
    logic        wd_en, wt_en, set_valid, clr_valid;
    logic [OFF_W-1:0] wd_off;
    logic [31:0] wd_data, wt_word;
    logic [3:0]  wd_par, wt_par;

    cpc_store #(.LINES(LINES), .WORDS(WORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (lat_idx),
        .rd_off   (lat_off),
        .rd_valid (rd_valid),
        .rd_tagw  (rd_tagw),
        .rd_tpar  (rd_tpar),
        .rd_data  (rd_data),
        .rd_dpar  (rd_dpar),
        .wd_en    (wd_en),
        .wd_off   (wd_off),
        .wd_data  (wd_data),
        .wd_par   (wd_par),
        .wt_en    (wt_en),
        .wt_word  (wt_word),
        .wt_par   (wt_par),
        .set_valid(set_valid),
        .clr_valid(clr_valid)
    );

    // parity generators: refill word, refill tag word, stored tag, stored word
    logic [31:0] fill_tagw;
    logic [3:0]  fill_dpar, fill_tpar, chk_tpar, chk_dpar;
    assign fill_tagw = {ctx, {PAD_W{1'b0}}, lat_tag};

    cpc_parity u_par_fill_d (.word(mem_data),  .par(fill_dpar));
    cpc_parity u_par_fill_t (.word(fill_tagw), .par(fill_tpar));
    cpc_parity u_par_chk_t  (.word(rd_tagw),   .par(chk_tpar));
    cpc_parity u_par_chk_d  (.word(rd_data),   .par(chk_dpar));

    logic is_diag, hit, tag_bad, data_bad;
    assign is_diag  = diag_en && (lat_asi[3:2] == 2'b11);
    assign hit      = rd_valid && (rd_tagw[TAG_W-1:0] == lat_tag);
    assign tag_bad  = (chk_tpar != rd_tpar);
    assign data_bad = (chk_dpar != rd_dpar);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_n = ST_LOOK;
            ST_LOOK: begin
                if (is_diag || lat_we)          state_n = ST_RESP;
                else if (hit && (tag_bad || data_bad)) state_n = ST_FLUSH;
                else if (hit)                   state_n = ST_RESP;
                else                            state_n = ST_FILL;
            end
            ST_FILL:  if (mem_valid && beat_q == LAST_BEAT) state_n = ST_LOOK;
            ST_FLUSH: state_n = ST_IDLE;
            ST_RESP:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // outputs and store controls
    always_comb begin
        wd_en     = 1'b0;
        wd_off    = lat_off;
        wd_data   = rd_data;
        wd_par    = rd_dpar;
        wt_en     = 1'b0;
        wt_word   = rd_tagw;
        wt_par    = rd_tpar;
        set_valid = 1'b0;
        clr_valid = 1'b0;
        inc_tag   = 1'b0;
        inc_data  = 1'b0;
        rdata_n   = rdata_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOOK: begin
                rdata_n = '0;
                if (is_diag && lat_we) begin
                    unique case (lat_asi[1:0])
                        DG_TPAR: begin wt_en = 1'b1; wt_par  = lat_wdata[3:0]; end
                        DG_CTX:  begin wt_en = 1'b1; wt_word = {lat_wdata[7:0], rd_tagw[23:0]}; end
                        DG_DPAR: begin wd_en = 1'b1; wd_par  = lat_wdata[3:0]; end
                        DG_WORD: begin wd_en = 1'b1; wd_data = lat_wdata; end
                        default: ;
                    endcase
                end else if (is_diag) begin
                    unique case (lat_asi[1:0])
                        DG_TPAR: rdata_n = {28'b0, rd_tpar};
                        DG_CTX:  rdata_n = {24'b0, rd_tagw[31:24]};
                        DG_DPAR: rdata_n = {28'b0, rd_dpar};
                        DG_WORD: rdata_n = rd_data;
                        default: ;
                    endcase
                end else if (!lat_we && hit && !tag_bad && !data_bad) begin
                    rdata_n = rd_data;
                end
            end
            ST_FILL: begin
                if (mem_valid) begin
                    wd_en   = 1'b1;
                    wd_off  = beat_q;
                    wd_data = mem_data;
                    wd_par  = fill_dpar;
                    if (beat_q == LAST_BEAT) begin
                        wt_en     = 1'b1;
                        wt_word   = fill_tagw;
                        wt_par    = fill_tpar;
                        set_valid = 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                clr_valid = 1'b1;
                inc_tag   = tag_err_q;
                inc_data  = data_err_q;
            end
            ST_RESP: ;
            default: ;
        endcase
    end

    // request latch and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_we     <= 1'b0;
            lat_asi    <= '0;
            lat_addr   <= '0;
            lat_wdata  <= '0;
            beat_q     <= '0;
            rdata_q    <= '0;
            tag_err_q  <= 1'b0;
            data_err_q <= 1'b0;
        end else begin
            rdata_q <= rdata_n;
            if (state_q == ST_IDLE && req_valid) begin
                lat_we    <= req_we;
                lat_asi   <= req_asi;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
            if (state_q == ST_LOOK) begin
                beat_q     <= '0;
                tag_err_q  <= tag_bad;
                data_err_q <= data_bad;
            end else if (state_q == ST_FILL && mem_valid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign resp_valid = (state_q == ST_RESP) || (state_q == ST_FLUSH);
    assign resp_retry = (state_q == ST_FLUSH);
    assign resp_data  = rdata_q;
    assign mem_req    = (state_q == ST_FILL);
    assign mem_addr   = {lat_tag, lat_idx, {(OFF_W+2){1'b0}}};

    a_r4_retry_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        resp_retry |-> (resp_valid && resp_data == '0));
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));
    a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W+1:0] == '0));
    a_r3_no_fill_while_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (!mem_req && !req_ready));
    a_r6_flush_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_retry |=> req_ready);
endmodule

// File: tb/test_cpc_cache.sv
module test_cpc_cache;
    localparam int WORDS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [3:0]  req_asi = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, resp_valid, resp_retry, mem_req;
    logic [31:0] resp_data, ctl_rdata;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_data = '0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    cpc_cache i_cpc_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_asi(req_asi), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_retry(resp_retry), .resp_data(resp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
    );

    function automatic logic [31:0] mw(input logic [15:0] a);
        return {a, a ^ 16'hBEEF};
    endfunction

    function automatic logic [3:0] par4(input logic [31:0] w);
        return {^w[31:24], ^w[23:16], ^w[15:8], ^w[7:0]};
    endfunction

    function automatic logic [31:0] tagword(input logic [7:0] c, input logic [15:0] a);
        return {c, 15'b0, a[15:7]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic [3:0] asi, input logic [15:0] addr,
                          input logic [31:0] wd, output logic [31:0] d, output logic rt,
                          output int fills);
        int beat = 0;
        fills = 0;
        d = '0;
        rt = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_asi = asi; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (mem_req) begin
                if (beat == 0) fills++;
                mem_valid = 1'b1;
                mem_data  = mw(mem_addr + 16'(beat * 4));
                beat = (beat + 1) % WORDS;
            end else begin
                mem_valid = 1'b0;
            end
            if (resp_valid) begin
                d = resp_data;
                rt = resp_retry;
                break;
            end
            if (i == 59) begin
                n_chk++; n_bad++;
                $display("FAIL request timeout actual=none expected=response");
            end
            @(negedge clk);
        end
        mem_valid = 1'b0;
    endtask

    task automatic ctl_write(input logic [31:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [3:0]  asi;
        logic [15:0] addr;
        logic [31:0] wd;
        logic [1:0]  fills;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'h0, 16'h0100, 32'h0,        2'd1},  // R2 miss
        '{1'b0, 4'h0, 16'h0104, 32'h0,        2'd0},  // R3 hit
        '{1'b0, 4'h0, 16'h010C, 32'h0,        2'd0},  // R3 hit last word
        '{1'b0, 4'h0, 16'h0230, 32'h0,        2'd1},  // R2 other line
        '{1'b0, 4'h0, 16'h0234, 32'h0,        2'd0},  // R3
        '{1'b0, 4'h0, 16'h0180, 32'h0,        2'd1},  // R2 conflict evicts
        '{1'b0, 4'h0, 16'h0100, 32'h0,        2'd1},  // R2 refetch
        '{1'b1, 4'h0, 16'h0104, 32'hDEADBEEF, 2'd0},  // R11 write ignored
        '{1'b0, 4'h0, 16'h0104, 32'h0,        2'd0},  // R11 word unchanged
        '{1'b0, 4'hC, 16'h0108, 32'h0,        2'd0}   // R12 code C, diag off
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        rt;
        int          f;
        int          dcnt;

        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 ready", 32'(req_ready), 32'd1);
        chk("R13 resp_valid", 32'(resp_valid), 32'd0);
        chk("R13 mem_req", 32'(mem_req), 32'd0);
        chk("R13 ctl", ctl_rdata, 32'd0);
        rst_n = 1'b1;

        ctl_write(32'h0000_5A00);
        chk("R8 ctl write", ctl_rdata, 32'h0000_5A00);

        for (int v = 0; v < NV; v++) begin
            do_req(VECS[v].we, VECS[v].asi, VECS[v].addr, VECS[v].wd, d, rt, f);
            chk($sformatf("R2/R3/R11/R12 vec%0d data", v), d,
                VECS[v].we ? 32'h0 : mw(VECS[v].addr));
            chk($sformatf("R2/R3 vec%0d fills", v), 32'(f), 32'(VECS[v].fills));
            chk($sformatf("R4 vec%0d no retry", v), 32'(rt), 32'd0);
        end

        // R9 / R1 diagnostics
        ctl_write(32'h0000_5A01);
        do_req(1'b0, 4'hC, 16'h0100, 0, d, rt, f);
        chk("R9 R1 tag parity", d, {28'b0, par4(tagword(8'h5A, 16'h0100))});
        do_req(1'b0, 4'hD, 16'h0100, 0, d, rt, f);
        chk("R9 context", d, 32'h5A);
        do_req(1'b0, 4'hE, 16'h0108, 0, d, rt, f);
        chk("R9 R1 data parity", d, {28'b0, par4(mw(16'h0108))});
        do_req(1'b0, 4'hF, 16'h0108, 0, d, rt, f);
        chk("R9 raw word", d, mw(16'h0108));

        // R10 plant data parity error
        do_req(1'b1, 4'hE, 16'h0108, {28'b0, par4(mw(16'h0108)) ^ 4'h1}, d, rt, f);
        chk("R10 diag write resp", d, 32'h0);
        do_req(1'b0, 4'hE, 16'h0108, 0, d, rt, f);
        chk("R10 parity kept raw", d, {28'b0, par4(mw(16'h0108)) ^ 4'h1});

        // R4 data error
        do_req(1'b0, 4'h0, 16'h0108, 0, d, rt, f);
        chk("R4 retry", 32'(rt), 32'd1);
        chk("R4 data zero", d, 32'h0);
        chk("R4 no fill", 32'(f), 32'd0);
        @(negedge clk);
        chk("R4 data counter", ctl_rdata, 32'h0000_5A11);
        // R6 retry refills
        do_req(1'b0, 4'h0, 16'h0108, 0, d, rt, f);
        chk("R6 refill", 32'(f), 32'd1);
        chk("R6 data", d, mw(16'h0108));
        chk("R6 no retry", 32'(rt), 32'd0);
        do_req(1'b0, 4'h0, 16'h0100, 0, d, rt, f);
        chk("R6 line hit after refill", 32'(f), 32'd0);

        // R5 tag error via context overwrite
        do_req(1'b1, 4'hD, 16'h0100, 32'h5B, d, rt, f);
        do_req(1'b0, 4'h0, 16'h0104, 0, d, rt, f);
        chk("R5 retry", 32'(rt), 32'd1);
        chk("R5 data zero", d, 32'h0);
        @(negedge clk);
        chk("R5 tag counter", ctl_rdata, 32'h0000_5A15);
        do_req(1'b0, 4'h0, 16'h0104, 0, d, rt, f);
        chk("R6 tag refill", 32'(f), 32'd1);
        chk("R6 tag refill data", d, mw(16'h0104));
        do_req(1'b0, 4'hD, 16'h0100, 0, d, rt, f);
        chk("R1 context restamped", d, 32'h5A);

        // R7 saturation through raw-word corruption
        dcnt = 1;
        for (int k = 0; k < 3; k++) begin
            do_req(1'b1, 4'hF, 16'h010C, 32'h0000_0001, d, rt, f);
            do_req(1'b0, 4'h0, 16'h010C, 0, d, rt, f);
            chk("R10 raw write causes retry", 32'(rt), 32'd1);
            dcnt = (dcnt < 3) ? dcnt + 1 : 3;
            @(negedge clk);
            chk("R7 data counter", 32'(ctl_rdata[5:4]), 32'(dcnt));
            do_req(1'b0, 4'h0, 16'h010C, 0, d, rt, f);
            chk("R6 refill after raw error", d, mw(16'h010C));
        end
        chk("R7 saturated", 32'(ctl_rdata[5:4]), 32'd3);

        // R8 clear semantics
        ctl_write(32'h0000_5A05);
        chk("R8 clear data keep tag", ctl_rdata, 32'h0000_5A05);
        ctl_write(32'h0000_5A01);
        chk("R8 clear tag", ctl_rdata, 32'h0000_5A01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule